// File: doc/BRIEF.md
# Buffered DMA Copy Engine

This block copies a programmed number of bytes between host memory and a 4096-byte local buffer that sits at device address 0x40000. Software loads a source address, a destination address and a byte count, then writes a command word. The command word holds a go bit, a direction bit and a completion-interrupt bit. The engine moves one byte per host transaction over a single-outstanding request/acknowledge port. It clears the go bit when the copy is done, and it can raise completion cause 0x100.

The direction bit decides which of the two addresses is the device-side address. That address must fall inside the local window. The other address is the host address, and only its low `HOST_BITS` bits (28 by default) reach the memory port. Software detects completion by polling the go bit.

The controller is a state machine with six states:
- `ST_IDLE` waits for a start write.
- `ST_LAUNCH` checks the window.
- `ST_HREAD` holds a host read until it is acknowledged.
- `ST_BFETCH` reads one buffer byte.
- `ST_HWRITE` holds a host write until it is acknowledged.
- `ST_FINISH` is the last busy cycle and carries the completion pulse.

Its transitions are:
- `ST_IDLE`→`ST_LAUNCH` on start.
- `ST_LAUNCH`→`ST_FINISH` when the window check fails.
- `ST_LAUNCH`→`ST_HREAD` for direction 0.
- `ST_LAUNCH`→`ST_BFETCH` for direction 1.
- `ST_HREAD`→`ST_HREAD` on a non-final acknowledge.
- `ST_HREAD`→`ST_FINISH` on the final acknowledge.
- `ST_BFETCH`→`ST_HWRITE`.
- `ST_HWRITE`→`ST_BFETCH` on a non-final acknowledge.
- `ST_HWRITE`→`ST_FINISH` on the final acknowledge.
- `ST_FINISH`→`ST_IDLE`.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset the go bit reads 0, all four registers read 0, `mem_req` is 0 and `irq_valid` is 0.
- R2: The registers sit at 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). An 8-byte access (`reg_size8`=1) at an 8-aligned offset reads or writes all 64 bits. A 4-byte access reaches bits 31:0 at the aligned offset and bits 63:32 at offset+4, and its read data is zero-extended. The command register reads back bit0 = go, bit1 = direction and bit2 = interrupt enable; every other bit reads 0.
- R3: A write to 0x98 with bit0 = 1 while idle starts a transfer. The go bit reads 1 from the cycle after that write until the transfer ends, and then reads 0.
- R4: With direction 0, byte i (i from 0 to count-1, ascending) is read from host address source+i and stored at buffer offset destination−0x40000+i. Each request is held with a stable address until `mem_ack`, and only one request is outstanding at a time.
- R5: With direction 1, buffer byte source−0x40000+i is written to host address destination+i with `mem_we`=1, in ascending order.
- R6: The host address on `mem_addr` is the programmed host-side address plus i, masked to its low `HOST_BITS` bits (default 28).
- R7: A transfer is refused when the count is zero, or when the device-side address is below 0x40000, or when device−0x40000+count exceeds 4096. A refused transfer issues no host request and keeps the go bit at 1 for exactly 2 cycles.
- R8: When command bit2 is set, `irq_valid` pulses for one cycle in the last busy cycle with `irq_cause` = 0x100. With bit2 clear there is no pulse, and `irq_cause` is 0 whenever `irq_valid` is 0.
- R9: Writes to all four registers are ignored while a transfer is running. This includes a second start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_rdata | output | 64 | Combinational register read data for `reg_addr` |
| mem_req | output | 1 | Host request, held until acknowledged |
| mem_we | output | 1 | 1 = host write, 0 = host read |
| mem_addr | output | HOST_BITS | Masked host byte address |
| mem_wdata | output | 8 | Host write byte |
| mem_ack | input | 1 | Host acknowledge; read data valid with it |
| mem_rdata | input | 8 | Host read byte |
| irq_valid | output | 1 | One-cycle completion pulse |
| irq_cause | output | 32 | Completion cause, 0x100 during the pulse |

## Verification
A start write at edge E puts the go bit at 1 in the cycle after E. The first host read request appears one cycle later, and the first host write request appears two cycles later because of the buffer fetch. The last busy cycle follows the cycle in which the final acknowledge is sampled, and the completion pulse appears in that cycle. A refused transfer spends exactly two cycles busy.

A behavioural model in the bench holds the expected address, direction, write byte and progress of every host request, and compares them on each falling edge. On those same falling edges it issues acknowledges after a fixed latency. The go bit is polled on falling edges from the cycle after the start write, so that each busy-cycle count is taken one sample per cycle.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_HREAD,
        ST_BFETCH,
        ST_HWRITE,
        ST_FINISH
    } dce_state_e;

    localparam logic [7:0]  OFF_SRC   = 8'h80;
    localparam logic [7:0]  OFF_DST   = 8'h88;
    localparam logic [7:0]  OFF_CNT   = 8'h90;
    localparam logic [7:0]  OFF_CMD   = 8'h98;
    localparam int          CMD_GO    = 0;
    localparam int          CMD_DIR   = 1;
    localparam int          CMD_IRQ   = 2;
    localparam logic [31:0] DONE_CAUSE = 32'h0000_0100;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [63:0] cnt;
        logic        to_host;
        logic        irq_en;
    } xfer_cfg_t;

endpackage

// File: rtl/dce_buf.sv
module dce_buf #(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/dce_regs.sv
module dce_regs
    import dce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [63:0] wdata,
    input  logic        size8,
    input  logic        busy,
    output logic [63:0] rdata,
    output logic        start,
    output xfer_cfg_t   cfg
);

    localparam int NUM_WIDE = 3;

    logic [63:0] wide_q [NUM_WIDE];
    logic [1:0]  cmd_q;
    logic        acc_ok;
    logic        wr_ok;
    logic        cmd_hit;

    // 8-byte accesses must be 8-aligned; 4-byte accesses select a half by addr[2]
    assign acc_ok  = !(size8 && addr[2]);
    assign wr_ok   = wr_en && !busy && acc_ok;
    assign cmd_hit = (addr[7:3] == OFF_CMD[7:3]) && !addr[2];
    assign start   = wr_ok && cmd_hit && wdata[CMD_GO];

    function automatic logic [63:0] merge(input logic [63:0] old,
                                          input logic [63:0] nv,
                                          input logic        wide,
                                          input logic        upper);
        if (wide)       return nv;
        else if (upper) return {nv[31:0], old[31:0]};
        else            return {old[63:32], nv[31:0]};
    endfunction

    for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
        localparam logic [4:0] SLOT = OFF_SRC[7:3] + 5'(k);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wide_q[k] <= '0;
            end else if (wr_ok && addr[7:3] == SLOT) begin
                wide_q[k] <= merge(wide_q[k], wdata, size8, addr[2]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_ok && cmd_hit) begin
            cmd_q <= {wdata[CMD_IRQ], wdata[CMD_DIR]};
        end
    end

    always_comb begin
        cfg.src     = wide_q[0];
        cfg.dst     = wide_q[1];
        cfg.cnt     = wide_q[2];
        cfg.to_host = cmd_q[0];
        cfg.irq_en  = cmd_q[1];
    end

    logic [63:0] word;
    always_comb begin
        unique case (addr[7:3])
            OFF_SRC[7:3]: word = wide_q[0];
            OFF_DST[7:3]: word = wide_q[1];
            OFF_CNT[7:3]: word = wide_q[2];
            OFF_CMD[7:3]: word = {61'd0, cmd_q[1], cmd_q[0], busy};
            default:      word = '0;
        endcase
        if (!acc_ok)      rdata = '0;
        else if (size8)   rdata = word;
        else if (addr[2]) rdata = {32'd0, word[63:32]};
        else              rdata = {32'd0, word[31:0]};
    end

    // R9: configuration frozen while a transfer runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));

    // R3: a start only happens from idle
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/dce_ctrl.sv
module dce_ctrl
    import dce_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h4_0000,
    parameter int          HOST_BITS = 28,
    localparam int         OFF_W     = $clog2(BUF_BYTES),
    localparam int         IDX_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  xfer_cfg_t            cfg,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [HOST_BITS-1:0] mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic                 mem_ack,
    input  logic [7:0]           mem_rdata,
    output logic                 buf_we,
    output logic                 buf_re,
    output logic [OFF_W-1:0]     buf_addr,
    output logic [7:0]           buf_wdata,
    input  logic [7:0]           buf_rdata,
    output logic                 irq_valid,
    output logic [31:0]          irq_cause
);

    localparam logic [63:0] SPAN = 64'(BUF_BYTES);

    dce_state_e state, state_n;
    logic [IDX_W-1:0] idx;
    logic [63:0]      dev_addr, host_addr, dev_off;
    logic             in_win, last;

    assign dev_addr  = cfg.to_host ? cfg.src : cfg.dst;
    assign host_addr = cfg.to_host ? cfg.dst : cfg.src;
    assign dev_off   = dev_addr - BUF_BASE;
    assign in_win    = (dev_addr >= BUF_BASE) && (cfg.cnt != 64'd0) &&
                       (cfg.cnt <= SPAN) && (dev_off <= SPAN - cfg.cnt);
    assign last      = (idx + IDX_W'(1)) == cfg.cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_LAUNCH;
            ST_LAUNCH: begin
                if (!in_win)          state_n = ST_FINISH;
                else if (cfg.to_host) state_n = ST_BFETCH;
                else                  state_n = ST_HREAD;
            end
            ST_HREAD:  if (mem_ack) state_n = last ? ST_FINISH : ST_HREAD;
            ST_BFETCH: state_n = ST_HWRITE;
            ST_HWRITE: if (mem_ack) state_n = last ? ST_FINISH : ST_BFETCH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (state == ST_LAUNCH) begin
            idx <= '0;
        end else if ((state == ST_HREAD || state == ST_HWRITE) && mem_ack) begin
            idx <= idx + IDX_W'(1);
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_HREAD) || (state == ST_HWRITE);
        mem_we    = (state == ST_HWRITE);
        mem_addr  = host_addr[HOST_BITS-1:0] + HOST_BITS'(idx);
        mem_wdata = buf_rdata;
        buf_we    = (state == ST_HREAD) && mem_ack;
        buf_re    = (state == ST_BFETCH);
        buf_addr  = dev_off[OFF_W-1:0] + OFF_W'(idx);
        buf_wdata = mem_rdata;
        irq_valid = (state == ST_FINISH) && cfg.irq_en;
        irq_cause = irq_valid ? DONE_CAUSE : 32'd0;
    end

    // R4: an unacknowledged request stays up with the same address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: progress never exceeds the count while requesting
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (64'(idx) < cfg.cnt));

    // R7: refused transfer: no request, then idle after one more cycle
    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAUNCH && !in_win) |=> (!mem_req && busy));

    // R8: completion pulse only in the last busy cycle
    p_irq_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !busy);

    // R8: cause is quiet while idle
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (irq_cause == 32'd0));

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dce_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h4_0000,
    parameter int          HOST_BITS = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [63:0]          reg_wdata,
    input  logic                 reg_size8,
    output logic [63:0]          reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [HOST_BITS-1:0] mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic                 mem_ack,
    input  logic [7:0]           mem_rdata,
    output logic                 irq_valid,
    output logic [31:0]          irq_cause
);

    localparam int OFF_W = $clog2(BUF_BYTES);

    xfer_cfg_t        cfg;
    logic             start, busy;
    logic             buf_we, buf_re;
    logic [OFF_W-1:0] buf_addr;
    logic [7:0]       buf_wdata, buf_rdata;

    dce_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .size8 (reg_size8),
        .busy  (busy),
        .rdata (reg_rdata),
        .start (start),
        .cfg   (cfg)
    );

    dce_ctrl #(
        .BUF_BYTES (BUF_BYTES),
        .BUF_BASE  (BUF_BASE),
        .HOST_BITS (HOST_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .buf_we    (buf_we),
        .buf_re    (buf_re),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .buf_rdata (buf_rdata),
        .irq_valid (irq_valid),
        .irq_cause (irq_cause)
    );

    dce_buf #(
        .DEPTH (BUF_BYTES)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .re    (buf_re),
        .addr  (buf_addr),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

endmodule

// File: tb/sim_dma_copy_engine.sv
`timescale 1ns/1ps
module sim_dma_copy_engine;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_size8 = 1'b1;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [27:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        irq_valid;
    logic [31:0] irq_cause;

    always #4 clk = ~clk;

    dma_copy_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_size8(reg_size8), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [7:0]  hmem [int];
    logic [7:0]  mbuf [4096];
    bit          m_active = 0;
    bit          m_dir = 0;
    logic [63:0] m_host = '0;
    int          m_off = 0;
    int          m_cnt = 0;
    int          m_i = 0;
    int          irq_seen = 0;
    int          waitc = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) ^ (a >>> 8));
    endfunction

    function automatic logic [7:0] hread(input int a);
        if (hmem.exists(a)) return hmem[a];
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle model comparison and host memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_valid) begin
                    irq_seen++;
                    check(irq_cause == 32'h100, "R8 cause", 64'(irq_cause), 64'h100);
                end else begin
                    check(irq_cause == 32'd0, "R8 quiet cause", 64'(irq_cause), 0);
                end
                if (mem_req) begin
                    logic [63:0] ea;
                    ea = (m_host + 64'(m_i)) & 64'h0FFF_FFFF;
                    check(m_active && m_i < m_cnt, "R7 unexpected request",
                          64'(m_i), 64'(m_cnt));
                    check(64'(mem_addr) == ea, "R6 host address", 64'(mem_addr), ea);
                    check(mem_we == m_dir, "R4/R5 direction", 64'(mem_we), 64'(m_dir));
                    if (m_dir)
                        check(mem_wdata == mbuf[(m_off + m_i) % 4096], "R5 write byte",
                              64'(mem_wdata), 64'(mbuf[(m_off + m_i) % 4096]));
                    waitc++;
                    if (waitc >= LAT) begin
                        mem_ack = 1'b1;
                        if (mem_we) begin
                            hmem[int'(mem_addr)] = mem_wdata;
                        end else begin
                            mem_rdata = hread(int'(mem_addr));
                            mbuf[(m_off + m_i) % 4096] = mem_rdata;
                        end
                        m_i++;
                        waitc = 0;
                    end else begin
                        mem_ack = 1'b0;
                    end
                end else begin
                    mem_ack = 1'b0;
                    waitc = 0;
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input bit s8);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_size8 = s8; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input bit s8, output logic [63:0] d);
        reg_addr = a; reg_size8 = s8;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(output int busy_cycles);
        logic [63:0] v;
        busy_cycles = 0;
        for (int n = 0; n < 20000; n++) begin
            rd(8'h98, 1'b1, v);
            if (!v[0]) return;
            busy_cycles++;
            @(negedge clk);
        end
        check(0, "R3 go bit never cleared", 64'(busy_cycles), 0);
    endtask

    task automatic xfer(input logic [63:0] src, input logic [63:0] dst,
                        input int cnt, input bit dir, input bit ien);
        logic [63:0] dev;
        bit ok;
        int bc, irq0;
        dev = dir ? src : dst;
        ok = (cnt != 0) && (dev >= 64'h40000) && (dev - 64'h40000 + 64'(cnt) <= 64'd4096);
        m_dir = dir; m_host = dir ? dst : src;
        m_off = int'(dev - 64'h40000); m_cnt = ok ? cnt : 0; m_i = 0;
        m_active = ok;
        irq0 = irq_seen;
        wr(8'h80, src, 1'b1);
        wr(8'h88, dst, 1'b1);
        wr(8'h90, 64'(cnt), 1'b1);
        wr(8'h98, {61'd0, ien, dir, 1'b1}, 1'b1);
        wait_done(bc);
        if (!ok) check(bc == 2, "R7 refused busy cycles", 64'(bc), 2);
        else     check(bc > cnt, "R3 busy while copying", 64'(bc), 64'(cnt));
        check(m_i == m_cnt, "R4/R5 byte count", 64'(m_i), 64'(m_cnt));
        check(irq_seen - irq0 == int'(ien), "R8 pulse count",
              64'(irq_seen - irq0), 64'(ien));
        m_active = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd(8'(8'h80 + 8 * k), 1'b1, v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check(!mem_req && !irq_valid, "R1 reset outputs", {mem_req, irq_valid}, 0);

        // R2 access widths
        wr(8'h80, 64'h1122_3344_5566_7788, 1'b1);
        rd(8'h80, 1'b1, v);
        check(v == 64'h1122_3344_5566_7788, "R2 8-byte readback", v, 64'h1122_3344_5566_7788);
        wr(8'h84, 64'hAABB_CCDD, 1'b0);
        rd(8'h80, 1'b1, v);
        check(v == 64'hAABB_CCDD_5566_7788, "R2 upper 4-byte write", v, 64'hAABB_CCDD_5566_7788);
        rd(8'h84, 1'b0, v);
        check(v == 64'hAABB_CCDD, "R2 upper 4-byte read", v, 64'hAABB_CCDD);
        rd(8'h80, 1'b0, v);
        check(v == 64'h5566_7788, "R2 lower 4-byte read", v, 64'h5566_7788);

        // R4 host to buffer, R3 go bit, R8 interrupt
        xfer(64'h1000, 64'h40010, 16, 1'b0, 1'b1);
        // R5 buffer to host
        xfer(64'h40010, 64'h2000, 16, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++)
            check(hread(32'h2000 + i) == pat(32'h1000 + i), "R5 round trip data",
                  64'(hread(32'h2000 + i)), 64'(pat(32'h1000 + i)));
        rd(8'h98, 1'b1, v);
        check(v == 64'h2, "R2 command readback", v, 64'h2);

        // R6 masking, window end boundary
        xfer(64'hF300_0200, 64'h40FFC, 4, 1'b0, 1'b1);
        xfer(64'h40FFC, 64'h5_0000_3000, 4, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)
            check(hread(32'h3000 + i) == pat(32'h0300_0200 + i), "R6 masked data",
                  64'(hread(32'h3000 + i)), 64'(pat(32'h0300_0200 + i)));

        // R7 refusals
        xfer(64'h4000, 64'h40FFD, 4, 1'b0, 1'b1);
        xfer(64'h40000, 64'h6000, 0, 1'b1, 1'b0);
        xfer(64'h3FFFF, 64'h6000, 1, 1'b1, 1'b1);

        // R9 writes ignored while running
        m_dir = 0; m_host = 64'h7000; m_off = 0; m_cnt = 8; m_i = 0; m_active = 1;
        wr(8'h80, 64'h7000, 1'b1);
        wr(8'h88, 64'h40000, 1'b1);
        wr(8'h90, 64'd8, 1'b1);
        wr(8'h98, 64'h1, 1'b1);
        wr(8'h80, 64'h9999, 1'b1);
        wr(8'h90, 64'd2, 1'b0);
        wr(8'h98, 64'h7, 1'b1);
        wait_done(bc);
        check(m_i == 8, "R9 count unchanged", 64'(m_i), 8);
        rd(8'h80, 1'b1, v);
        check(v == 64'h7000, "R9 source unchanged", v, 64'h7000);
        rd(8'h98, 1'b1, v);
        check(v == 64'h0, "R9 command unchanged", v, 0);
        m_active = 0;

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule